// File: doc/BRIEF.md
# Command-Byte Serial Register Access Sequencer

This block is the host side of a four-wire serial link to a slave device whose registers are reached through command bytes. The host presents one request, made of a direction, a register address, a byte count and right-justified write data. The sequencer then lowers chip select and runs the serial clock from a divider of the system clock. It shifts out a command byte followed by the data bytes. On a read, it gathers the bytes the slave returns into a right-justified result word. A one-cycle completion pulse marks the end of the frame.

The slave can lose the last byte of a write when a read command follows it too closely. To prevent this, the sequencer holds itself busy for a programmable number of clock cycles after any write frame ends, including a write that was cut short. An abort input ends a running frame at once by raising chip select.

Top module: `ser_txn_seq`

## Requirements
- R1: Each frame starts with an 8-bit command byte sent most significant bit first. Bit 7 is 1 for a write and 0 for a read, bits 6:5 are 0, and bits 4:0 carry the register address.
- R2: On a write of N bytes (N from 0 to MAX_BYTES), the low 8*N bits of the write data follow the command byte, most significant bit first. Bits above 8*N are never sent. With N = 0 the frame holds only the command byte.
- R3: On a read of N bytes, the host data line is 0 during the data bytes. The slave bits sampled during those bytes are assembled most significant bit first into the low 8*N bits of the result. All higher result bits are 0, and the result is valid when the completion pulse appears.
- R4: The serial clock idles high. A frame of NB = 8*(N+1) bits has exactly NB falling edges. The host data line changes only together with a rising serial clock edge while chip select is low.
- R5: Chip select stays low for exactly (2*NB+1)*HALF_DIV system clock cycles. The first falling serial clock edge comes HALF_DIV cycles after chip select falls. The completion pulse lasts one cycle and appears in the cycle where chip select returns high.
- R6: After a write frame ends, whether completed or aborted, chip select stays high for exactly GAP_CYC+1 cycles when a request is already waiting. After a read frame, a request waiting at the completion pulse starts its frame one cycle later.
- R7: The busy output is high from the acceptance of a request until the frame and any post-write gap are over, and chip select is high whenever busy is low. A request presented while busy is ignored: it does not change the running frame and starts no later frame.
- R8: An abort raised while a frame is active drives chip select and the serial clock high at the next clock edge. It gives a one-cycle abort pulse and no completion pulse. An abort raised while idle has no effect.
- R9: Under reset, chip select and the serial clock are high, busy, completion and abort pulses are low, and the result word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted in a cycle where busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_nbytes | input | CNT_W | Number of data bytes |
| req_wdata | input | 8*MAX_BYTES | Right-justified write data |
| abort | input | 1 | Ends an active frame immediately |
| busy | output | 1 | Frame or post-write gap in progress |
| done | output | 1 | One-cycle pulse at normal frame end |
| aborted | output | 1 | One-cycle pulse at aborted frame end |
| rdata | output | 8*MAX_BYTES | Right-justified read result |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Host-to-slave data |
| miso | input | 1 | Slave-to-host data |

## Verification
The hardest case to reach is a read waiting at the exact cycle the post-write gap runs out. This matters both after a completed write and after an aborted one. The stimulus reaches it by presenting each next request as soon as the previous frame ends and holding it until accepted. An address-by-count sweep alternates writes and reads, so every write-to-read and read-to-write handover is measured to the exact cycle. A stray request injected into a running frame and an abort in mid-frame cover the other paths that are hard to reach.

// File: rtl/ser_seq_pkg.sv
package ser_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_XFER = 2'd1,
      SEQ_TAIL = 2'd2
   } seq_state_e;

   // Direction flag on top, address zero-extended into the low seven bits.
   function automatic logic [7:0] make_cmd(input logic wr, input logic [6:0] addr);
      return {wr, addr};
   endfunction

endpackage

// File: rtl/ser_seq_tick.sv
module ser_seq_tick #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!run)       cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/ser_seq_gap.sv
module ser_seq_gap #(
   parameter int GAP_CYC = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic hold
);

   generate
      if (GAP_CYC == 0) begin : g_none
         assign hold = 1'b0;
      end else begin : g_timer
         localparam int GW = $clog2(GAP_CYC + 1);
         logic [GW-1:0] remain;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             remain <= '0;
            else if (start)         remain <= GW'(GAP_CYC);
            else if (remain != '0)  remain <= remain - 1'b1;
         end

         assign hold = (remain != '0);
      end
   endgenerate

endmodule

// File: rtl/ser_seq_shift.sv
module ser_seq_shift
   import ser_seq_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int MAX_BYTES = 3,
   parameter int CNT_W     = 2,
   parameter int DATA_W    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_wr,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [CNT_W-1:0]  load_nbytes,
   input  logic [DATA_W-1:0] load_wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              miso,
   output logic              mosi,
   output logic              last_bit,
   output logic [DATA_W-1:0] rdata
);

   localparam int TX_W  = 8 + DATA_W;
   localparam int BIT_W = $clog2(8 * (MAX_BYTES + 1) + 1);
   localparam logic [BIT_W-1:0] CMD_BITS = BIT_W'(8);

   logic [TX_W-1:0]   tx;
   logic [DATA_W-1:0] rx;
   logic [BIT_W-1:0]  bit_idx;
   logic [BIT_W-1:0]  total_bits;
   logic              wr_q;
   logic [CNT_W-1:0]  n_eff;
   logic [DATA_W-1:0] aligned;
   int                lsh;

   // Counts beyond the data width are limited to the widest frame.
   always_comb begin
      if (int'(load_nbytes) > MAX_BYTES) n_eff = CNT_W'(MAX_BYTES);
      else                               n_eff = load_nbytes;
   end

   // Move the right-justified payload up against the command byte.
   always_comb begin
      lsh     = DATA_W - 8 * int'(n_eff);
      aligned = load_wr ? (load_wdata << lsh) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx         <= '0;
         rx         <= '0;
         bit_idx    <= '0;
         total_bits <= CMD_BITS;
         wr_q       <= 1'b0;
      end else if (load) begin
         tx         <= {make_cmd(load_wr, 7'(load_addr)), aligned};
         rx         <= '0;
         bit_idx    <= '0;
         total_bits <= BIT_W'(8 * (int'(n_eff) + 1));
         wr_q       <= load_wr;
      end else begin
         if (rise && !last_bit) begin
            tx      <= {tx[TX_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
         end
         if (fall && !wr_q && (bit_idx >= CMD_BITS)) begin
            rx <= {rx[DATA_W-2:0], miso};
         end
      end
   end

   assign last_bit = (bit_idx == total_bits - 1'b1);
   assign mosi     = tx[TX_W-1];
   assign rdata    = rx;

endmodule

// File: rtl/ser_txn_seq.sv
module ser_txn_seq
   import ser_seq_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int MAX_BYTES = 3,
   parameter int HALF_DIV  = 4,
   parameter int GAP_CYC   = 400,
   localparam int DATA_W   = 8 * MAX_BYTES,
   localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CNT_W-1:0]  req_nbytes,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              abort,
   output logic              busy,
   output logic              done,
   output logic              aborted,
   output logic [DATA_W-1:0] rdata,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);

   generate
      if (ADDR_W < 1 || ADDR_W > 7) begin : g_bad_addr
         $error("ser_txn_seq: ADDR_W must lie in 1..7");
      end
      if (MAX_BYTES < 1) begin : g_bad_bytes
         $error("ser_txn_seq: MAX_BYTES must be at least 1");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("ser_txn_seq: HALF_DIV must be at least 1");
      end
      if (GAP_CYC < 0) begin : g_bad_gap
         $error("ser_txn_seq: GAP_CYC must not be negative");
      end
   endgenerate

   seq_state_e state;
   logic       tick;
   logic       run;
   logic       accept;
   logic       rise;
   logic       fall;
   logic       last_bit;
   logic       cur_wr;
   logic       ending;
   logic       gap_start;
   logic       gap_hold;

   assign run    = (state != SEQ_IDLE);
   assign accept = req_valid && !busy;
   assign rise   = tick && (state == SEQ_XFER) && !sclk;
   assign fall   = tick && (state == SEQ_XFER) && sclk;
   assign ending = run && (abort || ((state == SEQ_TAIL) && tick));
   assign gap_start = ending && cur_wr;
   assign busy   = run || gap_hold;

   ser_seq_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   ser_seq_gap #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (gap_start),
      .hold  (gap_hold)
   );

   ser_seq_shift #(
      .ADDR_W    (ADDR_W),
      .MAX_BYTES (MAX_BYTES),
      .CNT_W     (CNT_W),
      .DATA_W    (DATA_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (accept),
      .load_wr     (req_write),
      .load_addr   (req_addr),
      .load_nbytes (req_nbytes),
      .load_wdata  (req_wdata),
      .rise        (rise),
      .fall        (fall),
      .miso        (miso),
      .mosi        (mosi),
      .last_bit    (last_bit),
      .rdata       (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         cs_n    <= 1'b1;
         sclk    <= 1'b1;
         done    <= 1'b0;
         aborted <= 1'b0;
         cur_wr  <= 1'b0;
      end else begin
         done    <= 1'b0;
         aborted <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  state  <= SEQ_XFER;
                  cs_n   <= 1'b0;
                  sclk   <= 1'b1;
                  cur_wr <= req_write;
               end
            end
            SEQ_XFER: begin
               if (abort) begin
                  state   <= SEQ_IDLE;
                  cs_n    <= 1'b1;
                  sclk    <= 1'b1;
                  aborted <= 1'b1;
               end else if (tick) begin
                  sclk <= ~sclk;
                  if (rise && last_bit) state <= SEQ_TAIL;
               end
            end
            SEQ_TAIL: begin
               if (abort) begin
                  state   <= SEQ_IDLE;
                  cs_n    <= 1'b1;
                  aborted <= 1'b1;
               end else if (tick) begin
                  state <= SEQ_IDLE;
                  cs_n  <= 1'b1;
                  done  <= 1'b1;
               end
            end
            default: begin
               state <= SEQ_IDLE;
               cs_n  <= 1'b1;
               sclk  <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/ser_txn_seq_chk.sv
module ser_txn_seq_chk #(
   parameter int GAP_CYC = 400
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_write,
   input logic abort,
   input logic busy,
   input logic done,
   input logic aborted,
   input logic cs_n,
   input logic sclk,
   input logic mosi
);

   localparam int IW = $clog2(GAP_CYC + 2);
   localparam logic [IW-1:0] SAT = IW'(GAP_CYC + 1);

   logic [IW-1:0] idle_cnt;
   logic          cur_wr;
   logic          last_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
         cur_wr   <= 1'b0;
         last_wr  <= 1'b0;
      end else begin
         if (!cs_n)               idle_cnt <= '0;
         else if (idle_cnt != SAT) idle_cnt <= idle_cnt + 1'b1;
         if (req_valid && !busy) begin
            last_wr <= cur_wr;
            cur_wr  <= req_write;
         end
      end
   end

   // R4
   sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R4
   mosi_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $rose(sclk));

   // R5
   done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && $past(!cs_n)));

   // R8
   end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !aborted);

   // R8
   abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !cs_n) |=> (cs_n && sclk && aborted));

   // R7
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   // R6
   write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n) && last_wr) |-> (idle_cnt >= IW'(GAP_CYC)));

endmodule

bind ser_txn_seq ser_txn_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .abort     (abort),
   .busy      (busy),
   .done      (done),
   .aborted   (aborted),
   .cs_n      (cs_n),
   .sclk      (sclk),
   .mosi      (mosi)
);

// File: tb/ser_txn_seq_bench.sv
module ser_txn_seq_bench;

   localparam int HD  = 2;
   localparam int MB  = 2;
   localparam int GAP = 20;
   localparam int DW  = 8 * MB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [4:0]    req_addr = '0;
   logic [1:0]    req_nbytes = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          abort = 1'b0;
   logic          busy, done, aborted, cs_n, sclk, mosi;
   logic          miso = 1'b0;
   logic [DW-1:0] rdata;

   always #5 clk = ~clk;

   ser_txn_seq #(.MAX_BYTES(MB), .HALF_DIV(HD), .GAP_CYC(GAP)) u_ser_txn_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_nbytes(req_nbytes), .req_wdata(req_wdata),
      .abort(abort), .busy(busy), .done(done), .aborted(aborted), .rdata(rdata),
      .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit last_wr_flag = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Slave model: samples on falling SCLK, drives read bits on rising SCLK.
   logic [63:0] sh = '0;
   int          fall_cnt = 0;
   int          cur_n = 0;
   logic [31:0] rd_exp = '0;

   always @(negedge cs_n) begin
      fall_cnt = 0;
      sh = '0;
      miso = 1'b0;
   end
   always @(negedge sclk) if (!cs_n) begin
      sh = {sh[62:0], mosi};
      fall_cnt++;
   end
   always @(posedge sclk) if (!cs_n && fall_cnt >= 8) begin
      if (fall_cnt - 8 < 8 * cur_n) miso = rd_exp[8 * cur_n - 1 - (fall_cnt - 8)];
      else                          miso = 1'b0;
   end

   // Edge-time monitor
   logic prev_cs = 1'b1;
   logic prev_sclk = 1'b1;
   int   t_fall = 0, t_rise = 0, t_sf1 = 0;
   always @(negedge clk) begin
      if (prev_cs && !cs_n) t_fall = cyc;
      if (!prev_cs && cs_n) t_rise = cyc;
      if (prev_sclk && !sclk && !cs_n && fall_cnt == 1) t_sf1 = cyc;
      prev_cs = cs_n;
      prev_sclk = sclk;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_txn(input bit wr, input int addr, input int n, input logic [DW-1:0] wd,
                          input logic [31:0] rdv, input int abort_at, input int spur_at,
                          input bit b2b);
      int          prev_rise;
      int          cnt;
      int          nb;
      logic [31:0] mask;
      logic [7:0]  cmd_got;
      logic [7:0]  cmd_exp;
      bit          quiet;
      prev_rise = t_rise;
      cur_n = n;
      rd_exp = rdv;
      nb = 8 * (1 + n);
      mask = (n == 0) ? 32'd0 : ((32'd1 << (8 * n)) - 32'd1);
      req_write = wr;
      req_addr = addr[4:0];
      req_nbytes = n[1:0];
      req_wdata = wd;
      while (busy) begin @(negedge clk); #1; end
      req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
      cnt = 0;
      forever begin
         @(negedge clk); #1;
         cnt++;
         req_valid = 1'b0;
         abort = 1'b0;
         if (done || aborted) break;
         if (cnt == spur_at) begin
            req_valid = 1'b1;
            req_write = ~wr;
            req_addr = addr[4:0] ^ 5'h1F;
         end
         if (cnt == abort_at) abort = 1'b1;
      end
      if (b2b) begin
         if (last_wr_flag)
            chk(t_fall - prev_rise == GAP + 1, "R6 gap after write", t_fall - prev_rise, GAP + 1);
         else
            chk(t_fall - prev_rise == 1, "R6 no gap after read", t_fall - prev_rise, 1);
      end
      if (abort_at > 0) begin
         chk(aborted && !done, "R8 abort pulse without done", {aborted, done}, 2'b10);
         chk(cs_n && sclk, "R8 lines released on abort", {cs_n, sclk}, 2'b11);
         chk(fall_cnt < nb, "R8 frame cut short", fall_cnt, nb);
      end else begin
         chk(done && !aborted && cs_n, "R5 done with release", {done, aborted, cs_n}, 3'b101);
         cmd_got = 8'(sh >> (8 * n));
         cmd_exp = {wr, 2'b00, addr[4:0]};
         chk(cmd_got == cmd_exp, "R1 command byte", cmd_got, cmd_exp);
         if (wr) begin
            chk((sh[31:0] & mask) == (32'(wd) & mask), "R2 write payload",
                sh[31:0] & mask, 32'(wd) & mask);
         end else begin
            chk((sh[31:0] & mask) == 0, "R3 host line low in read data", sh[31:0] & mask, 0);
            chk(32'(rdata) == (rdv & mask), "R3 read result", rdata, rdv & mask);
         end
         chk(fall_cnt == nb, "R4 falling edge count", fall_cnt, nb);
         chk(t_rise - t_fall == (2 * nb + 1) * HD, "R5 select width",
             t_rise - t_fall, (2 * nb + 1) * HD);
         chk(t_sf1 - t_fall == HD, "R5 first edge delay", t_sf1 - t_fall, HD);
      end
      last_wr_flag = wr;
      if (spur_at > 0) begin
         quiet = 1'b1;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (!cs_n || busy) quiet = 1'b0;
         end
         chk(quiet, "R7 request during busy ignored", quiet, 1);
      end
   endtask

   initial begin
      wait (cyc > 150000);
      fails++;
      $display("FAIL watchdog expired, no requirement completed");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit first;
      bit idle_ok;
      repeat (3) @(negedge clk);
      #1;
      // R9 reset state
      chk(cs_n && sclk, "R9 lines high in reset", {cs_n, sclk}, 2'b11);
      chk(!busy && !done && !aborted, "R9 flags low in reset", {busy, done, aborted}, 0);
      chk(rdata == '0, "R9 result cleared in reset", rdata, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(cs_n && sclk && !busy, "R9 idle after reset", {cs_n, sclk, busy}, 3'b110);

      first = 1'b1;
      for (int a = 0; a < 32; a++) begin
         for (int n = 0; n <= MB; n++) begin
            for (int d = 1; d >= 0; d--) begin
               run_txn(d[0], a, n, DW'((a * 263 + n * 4099) ^ 16'hA5C3),
                       32'((a * 37 + n * 11 + 5) * 97), 0, 0, !first);
               first = 1'b0;
            end
         end
      end

      // R7: stray request in the middle of a read frame
      run_txn(1'b0, 9, 2, 16'h0000, 32'h5A3C, 0, 6, 1'b1);

      // R8: abort a write mid-frame, then R6 gap before the following read
      run_txn(1'b1, 3, 2, 16'hBEEF, 32'h0, 15, 0, 1'b0);
      run_txn(1'b0, 4, 1, 16'h0000, 32'h00C6, 0, 0, 1'b1);

      // R8: abort while idle has no effect
      idle_ok = 1'b1;
      abort = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         if (!cs_n || aborted || busy || !sclk) idle_ok = 1'b0;
      end
      abort = 1'b0;
      chk(idle_ok, "R8 idle abort ignored", idle_ok, 1);
      run_txn(1'b1, 31, 2, 16'h1234, 32'h0, 0, 0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule